// File: doc/BRIEF.md
# Multicast Output-Queue Address Manager

This block keeps the per-output queues of a shared cell buffer. Each output port has its own FIFO of buffer addresses. An arriving cell carries a bitmap of destination ports. The block takes one vacant address from an idle-address pool and pushes that address into every selected output FIFO in the same cycle. One-hot, multi-bit and all-ones bitmaps therefore give unicast, multicast and broadcast, and each costs a single write. The cell payload memory and the line multiplexing sit outside the block. The block only returns the address under which the payload is to be stored.

The read side serves the outputs in a fixed rotation, one port per service slot. Each served port yields the address at the head of its FIFO. Every address carries a copy counter, set to the number of destinations when the cell is accepted and decremented on each read. The address goes back to the idle pool only when the last copy has left. A cell that cannot be placed in full is refused as a whole, and a drop pulse is raised.

Top module: `mcq_manager`

## Requirements
- R1: After reset, `grant_valid`, `drop` and `out_valid` are low and every output FIFO is empty. Addresses are granted in ascending order 0, 1, ..., NCELLS-1 before any recycled address is granted.
- R2: An accepted cell gives `grant_valid` high for one cycle in the cycle after the request, with the granted address on `grant_addr`. `grant_valid` and `drop` are never high together.
- R3: A granted address is pushed into the FIFO of every port whose bit in `cell_dest` is 1 (bit i selects port i). Each of those ports later delivers that same address.
- R4: A request with `cell_valid` low, or with `cell_dest` all zeros, gives neither grant nor drop and consumes no address. The next accepted cell receives the address it would have received anyway.
- R5: Each cycle with `serve_en` high serves the port named by a rotating pointer. The pointer starts at 0 and advances by one modulo NPORTS on every `serve_en`, whether the queue is empty or not. In the next cycle `out_valid` is high with `out_port` and `out_addr` if that queue held an entry, and low otherwise.
- R6: Each port delivers its addresses in the order they were queued. An address queued in a cycle cannot be served to an empty port in that same cycle.
- R7: An address rejoins the idle pool only after every copy has been read. Once the ascending addresses are used up, recycled addresses are granted in the order they were released.
- R8: When the idle pool is empty at the start of a cycle, a request is dropped: `drop` pulses in the next cycle and nothing is queued. An address released in that same cycle becomes grantable only from the next cycle on.
- R9: When any selected FIFO is full (occupancy counted before that cycle's service), the whole cell is dropped. No selected port receives it, and no address is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_valid | input | 1 | Arriving cell request |
| cell_dest | input | NPORTS | Destination bitmap, bit i selects port i |
| serve_en | input | 1 | Service slot: read the current port in the rotation |
| grant_valid | output | 1 | Registered: cell accepted |
| grant_addr | output | log2(NCELLS) | Buffer address for the accepted cell |
| drop | output | 1 | Registered: cell refused |
| out_valid | output | 1 | Registered: a head-of-line address was read |
| out_port | output | log2(NPORTS) | Port that was served |
| out_addr | output | log2(NCELLS) | Address read from that port |

## Verification
The bench sends a lone unicast, a two-port multicast and a full broadcast. Comparing the read-out addresses per port separates a correct parallel enqueue from one that misses or duplicates a destination. Empty and invalid bitmaps are placed between accepted cells, so that any address lost to them shows up as a gap in the grant sequence. Long fills against a reduced queue depth reach the full-queue and empty-pool refusals separately. Writes that coincide with service slots show whether a freed address is recycled too early or in the wrong order.

// File: rtl/mcq_pkg.sv
package mcq_pkg;

  // number of ones in a destination bitmap (up to 32 ports)
  function automatic int unsigned bits_set(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/mcq_fifo.sv
module mcq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/mcq_free_pool.sv
module mcq_free_pool #(
  parameter int NCELLS = 16,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  input  logic [AW-1:0] give_addr,
  output logic          avail,
  output logic [AW-1:0] addr
);
  localparam int FW = $clog2(NCELLS + 1);

  // never-used addresses come from a counter, so reset needs no RAM fill
  logic [FW-1:0] fresh;
  logic          from_fresh;
  logic          rec_empty, rec_full;
  logic [AW-1:0] rec_head;

  assign from_fresh = (fresh != FW'(NCELLS));

  mcq_fifo #(.DEPTH(NCELLS), .W(AW)) u_recycle (
    .clk   (clk),
    .rst   (rst),
    .push  (give && !rec_full),
    .pop   (take && !from_fresh),
    .din   (give_addr),
    .dout  (rec_head),
    .empty (rec_empty),
    .full  (rec_full)
  );

  always_ff @(posedge clk) begin
    if (rst)                    fresh <= '0;
    else if (take && from_fresh) fresh <= fresh + 1'b1;
  end

  assign avail = from_fresh || !rec_empty;
  assign addr  = from_fresh ? fresh[AW-1:0] : rec_head;
endmodule

// File: rtl/mcq_refcnt.sv
module mcq_refcnt #(
  parameter int NCELLS = 16,
  parameter int AW     = 4,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [CW-1:0] set_val,
  input  logic          dec_en,
  input  logic [AW-1:0] dec_addr,
  output logic          last_copy
);
  // a set address is always free and a decremented one always in use,
  // so the two ports never meet on one entry
  logic [CW-1:0] cnt [NCELLS];

  always_ff @(posedge clk) begin
    if (set_en) cnt[set_addr] <= set_val;
    if (dec_en) cnt[dec_addr] <= cnt[dec_addr] - 1'b1;
  end

  assign last_copy = dec_en && (cnt[dec_addr] == CW'(1));
endmodule

// File: rtl/mcq_manager.sv
module mcq_manager
  import mcq_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NCELLS = 16,
  parameter int QDEPTH = NCELLS,
  localparam int AW  = $clog2(NCELLS),
  localparam int PSW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_valid,
  input  logic [NPORTS-1:0] cell_dest,
  input  logic              serve_en,
  output logic              grant_valid,
  output logic [AW-1:0]     grant_addr,
  output logic              drop,
  output logic              out_valid,
  output logic [PSW-1:0]    out_port,
  output logic [AW-1:0]     out_addr
);
  localparam int CW = $clog2(NPORTS + 1);

  logic [NPORTS-1:0] q_full, q_empty;
  logic [AW-1:0]     q_head [NPORTS];
  logic              pool_avail;
  logic [AW-1:0]     pool_addr;
  logic              want, blocked, take, reject;
  logic [PSW-1:0]    rr;
  logic              serve_hit;
  logic [AW-1:0]     head_sel;
  logic              last_copy;
  logic [CW-1:0]     copies;

  assign want      = cell_valid && (|cell_dest);
  assign blocked   = |(cell_dest & q_full);
  assign take      = want && pool_avail && !blocked;
  assign reject    = want && !take;
  assign serve_hit = serve_en && !q_empty[rr];
  assign head_sel  = q_head[rr];
  assign copies    = CW'(bits_set(32'(cell_dest)));

  generate
    for (genvar g = 0; g < NPORTS; g++) begin : g_q
      mcq_fifo #(.DEPTH(QDEPTH), .W(AW)) u_q (
        .clk   (clk),
        .rst   (rst),
        .push  (take && cell_dest[g]),
        .pop   (serve_hit && (rr == PSW'(g))),
        .din   (pool_addr),
        .dout  (q_head[g]),
        .empty (q_empty[g]),
        .full  (q_full[g])
      );
    end
  endgenerate

  mcq_free_pool #(.NCELLS(NCELLS), .AW(AW)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .give      (last_copy),
    .give_addr (head_sel),
    .avail     (pool_avail),
    .addr      (pool_addr)
  );

  mcq_refcnt #(.NCELLS(NCELLS), .AW(AW), .CW(CW)) u_ref (
    .clk       (clk),
    .set_en    (take),
    .set_addr  (pool_addr),
    .set_val   (copies),
    .dec_en    (serve_hit),
    .dec_addr  (head_sel),
    .last_copy (last_copy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr          <= '0;
      grant_valid <= 1'b0;
      grant_addr  <= '0;
      drop        <= 1'b0;
      out_valid   <= 1'b0;
      out_port    <= '0;
      out_addr    <= '0;
    end else begin
      grant_valid <= take;
      grant_addr  <= pool_addr;
      drop        <= reject;
      out_valid   <= serve_hit;
      out_port    <= rr;
      out_addr    <= head_sel;
      if (serve_en) rr <= (rr == PSW'(NPORTS - 1)) ? '0 : rr + 1'b1;
    end
  end
endmodule

// File: rtl/mcq_manager_chk.sv
module mcq_manager_chk #(
  parameter int NPORTS = 4,
  parameter int PSW    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cell_valid,
  input logic [NPORTS-1:0] cell_dest,
  input logic              serve_en,
  input logic              grant_valid,
  input logic              drop,
  input logic              out_valid,
  input logic [PSW-1:0]    out_port
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!grant_valid && !drop && !out_valid));

  // R2
  grant_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && drop));

  // R4
  empty_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cell_valid || (cell_dest == '0)) |-> (!grant_valid && !drop));

  // R8
  drop_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    drop |-> ($past(cell_valid) && $past(|cell_dest)));

  // R5
  serve_needs_slot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(serve_en));

  // R5
  rotation_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |->
      (out_port == (($past(out_port) == PSW'(NPORTS - 1)) ? '0 : $past(out_port) + 1'b1)));
endmodule

bind mcq_manager mcq_manager_chk #(.NPORTS(NPORTS), .PSW(PSW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cell_valid  (cell_valid),
  .cell_dest   (cell_dest),
  .serve_en    (serve_en),
  .grant_valid (grant_valid),
  .drop        (drop),
  .out_valid   (out_valid),
  .out_port    (out_port)
);

// File: tb/tb_mcq_manager.sv
module tb_mcq_manager;
  localparam int NP = 4;
  localparam int NC = 8;
  localparam int QD = 4;
  localparam int AW = $clog2(NC);
  localparam int PSW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cell_valid = 1'b0;
  logic [NP-1:0] cell_dest = '0;
  logic          serve_en = 1'b0;
  logic          grant_valid, drop, out_valid;
  logic [AW-1:0] grant_addr, out_addr;
  logic [PSW-1:0] out_port;

  always #10 clk = ~clk;

  mcq_manager #(.NPORTS(NP), .NCELLS(NC), .QDEPTH(QD)) dut (
    .clk, .rst, .cell_valid, .cell_dest, .serve_en,
    .grant_valid, .grant_addr, .drop, .out_valid, .out_port, .out_addr
  );

  typedef struct {
    bit gv; int ga; bit dr; bit ov; int op; int oa; string tag; longint t;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0, n_fail = 0;

  // reference model built from the requirements
  int mfresh = 0;
  int mpool[$];
  int mq[NP][$];
  int mref[NC];
  int mrr = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input bit v, input logic [NP-1:0] d, input bit rd, input string tag);
    exp_t e;
    bit want, avail, blk, hit;
    int a, rp, ncp;
    e.gv = 0; e.ga = 0; e.dr = 0; e.ov = 0; e.op = 0; e.oa = 0; e.tag = tag; e.t = $time;
    want  = v && (d != '0);
    avail = (mfresh < NC) || (mpool.size() > 0);
    blk   = 0;
    ncp   = 0;
    for (int p = 0; p < NP; p++) if (d[p]) begin
      ncp++;
      if (mq[p].size() == QD) blk = 1;
    end
    rp  = mrr;
    hit = rd && (mq[rp].size() > 0);
    if (want && avail && !blk) begin
      if (mfresh < NC) begin a = mfresh; mfresh++; end
      else a = mpool.pop_front();
      for (int p = 0; p < NP; p++) if (d[p]) mq[p].push_back(a);
      mref[a] = ncp;
      e.gv = 1; e.ga = a;
    end else if (want) begin
      e.dr = 1;
    end
    if (hit) begin
      e.ov = 1; e.op = rp; e.oa = mq[rp].pop_front();
      mref[e.oa]--;
      if (mref[e.oa] == 0) mpool.push_back(e.oa);
    end
    if (rd) mrr = (mrr + 1) % NP;
    cell_valid = v; cell_dest = d; serve_en = rd;
    expq.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares each cycle's registered outputs with the queued item
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (expq.size() > 0 && expq[0].t < $time - 1) begin
        e = expq.pop_front();
        check(grant_valid == e.gv && (!e.gv || int'(grant_addr) == e.ga), e.tag, "grant",
              e.gv ? int'(grant_addr) : int'(grant_valid), e.gv ? e.ga : 0);
        check(drop == e.dr, e.tag, "drop", int'(drop), int'(e.dr));
        check(out_valid == e.ov && (!e.ov || (int'(out_port) == e.op && int'(out_addr) == e.oa)),
              e.tag, "serve", out_valid ? int'(out_port) * 100 + int'(out_addr) : -1,
              e.ov ? e.op * 100 + e.oa : -1);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs while and right after reset
    check(!grant_valid && !drop && !out_valid, "R1", "reset outputs",
          int'(grant_valid) + int'(drop) + int'(out_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < NP; i++) step(0, '0, 1, "R1");      // empty queues
    step(1, 4'b0100, 0, "R2");                               // unicast, addr 0
    step(1, 4'b1001, 0, "R3");                               // multicast, addr 1
    step(1, 4'b1111, 0, "R3");                               // broadcast, addr 2
    step(1, 4'b0000, 0, "R4");                               // empty bitmap
    step(0, 4'b1111, 0, "R4");                               // valid low
    step(1, 4'b0010, 0, "R4");                               // must get addr 3
    for (int i = 0; i < NP; i++) step(0, '0, 1, "R5");
    for (int i = 0; i < NP; i++) step(0, '0, 1, "R6");
    for (int i = 0; i < 6; i++) step(1, 4'b0001, 1, "R7");   // writes racing reads
    for (int i = 0; i < 12; i++) step(0, '0, 1, "R6");       // drain
    for (int i = 0; i < QD; i++) step(1, 4'b0001, 0, "R9");  // fill port 0
    step(1, 4'b0011, 0, "R9");                               // refused whole
    step(1, 4'b0010, 0, "R9");                               // port 1 alone fine
    for (int i = 0; i < 3; i++) step(1, 4'b0100, 0, "R8");   // use last addresses
    step(1, 4'b1000, 0, "R8");                               // pool empty
    step(1, 4'b1000, 1, "R8");                               // release same cycle
    step(1, 4'b1000, 0, "R7");                               // freed address now
    for (int i = 0; i < 20; i++) step(0, '0, 1, "R6");
    step(1, 4'b1111, 0, "R3");
    for (int i = 0; i < 8; i++) step(0, '0, 1, "R7");
    step(1, 4'b0110, 0, "R7");
    for (int i = 0; i < 4; i++) step(0, '0, 1, "R3");
    for (int i = 0; i < 3; i++) step(0, '0, 0, "R2");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule